// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a processor core goes into its low-power state and when it comes back out. The core asks to sleep in one of two ways. A wait-for-event request sleeps until any wake event arrives. A wait-for-interrupt request sleeps until an interrupt wakes it. A third path is an exception return to thread mode while the sleep-on-exit control is set: the core then sleeps in the same way as for a wait-for-interrupt request. The block reports a sleeping flag and a deep-sleep flag, and it gives a single-cycle wake pulse when the core is released.

A one-bit event register remembers a wake event that arrives while the core is not sleeping in wait-for-event. A later wait-for-event then sees the stored event, clears it and does not sleep. Wake events are a send-event indication, an external event pulse, or an interrupt that has just become pending. The send-event-on-pending control decides whether an interrupt that is disabled may also count as a wake event. A small control word sets the three options. It is read and written through a synchronous write-enable port.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: The control word holds send-event-on-pending at bit 4, deep-sleep select at bit 2 and sleep-on-exit at bit 1. A write takes effect at the clock edge and reads back on the next cycle. All other bits read as 0 and ignore writes.
- R2: A wait-for-event request, when the event register is clear and no wake event is present, sets the sleeping flag on the cycle after the request. On entry, the deep-sleep flag copies the deep-sleep select bit (0 = ordinary sleep, 1 = deep sleep).
- R3: When the core sleeps in wait-for-event, a send-event or external event pulse raises the wake pulse on the next cycle. The pulse lasts exactly one cycle, and the sleeping and deep-sleep flags clear on the cycle after the pulse.
- R4: An interrupt is a wake event only when its pending bit goes from 0 to 1. An enabled interrupt that rises wakes a wait-for-interrupt sleep. An interrupt that stays pending causes no further wake.
- R5: When send-event-on-pending is 0, a rising pending bit whose enable bit is 0 neither wakes the core nor sets the event register. When send-event-on-pending is 1, such a rising bit wakes a wait-for-event sleep.
- R6: A wake event that arrives while the core is awake sets the event register. The next wait-for-event clears the register and leaves the sleeping flag at 0. The wait-for-event after that one sleeps.
- R7: During a wait-for-interrupt sleep, send-event and external event pulses do not wake the core, but they set the event register.
- R8: An exception return to thread mode puts the core into a wait-for-interrupt sleep, with the mode chosen by deep-sleep select, when sleep-on-exit is 1. It has no effect when sleep-on-exit is 0.
- R9: If a wake event is present in the same cycle as a wait-for-event request, or an interrupt wake in the same cycle as a wait-for-interrupt request, the core does not sleep and the event register ends clear.
- R10: After reset, the control word reads 0, all outputs are 0 and the event register is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write enable |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| wfe_req | input | 1 | Wait-for-event request |
| wfi_req | input | 1 | Wait-for-interrupt request |
| sev_exec | input | 1 | Send-event executed |
| ext_event | input | 1 | External event pulse |
| irq_pending | input | NUM_IRQ | Per-interrupt pending vector |
| irq_enable | input | NUM_IRQ | Per-interrupt enable vector |
| exc_ret_thread | input | 1 | Exception return to thread mode strobe |
| sleeping | output | 1 | Core is in a low-power state |
| deep_sleep | output | 1 | Low-power state is deep sleep |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
Some properties are checked by the assertions on every cycle. The wake pulse never lasts two cycles. The flags always clear right after a wake. Deep sleep never shows without sleeping. A stored event stops a wait-for-event from sleeping. Event pulses never release a wait-for-interrupt sleep. With no enabled pending interrupt and no event, nothing is reported as a wake source. Other behaviour can only be shown by the bench's scenarios: the event register carrying over from one request to a later one, a held pending bit staying quiet, disabled interrupts being ignored or counted as the control bit selects, and the register read-back layout.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    PS_AWAKE  = 2'd0,
    PS_WFE    = 2'd1,
    PS_WFI    = 2'd2,
    PS_WAKING = 2'd3
  } pwr_state_t;

  localparam int unsigned BIT_SEV_ON_PEND = 4;
  localparam int unsigned BIT_DEEP_SEL    = 2;
  localparam int unsigned BIT_ON_EXIT     = 1;

  typedef struct packed {
    logic sev_on_pend;
    logic deep_sel;
    logic sleep_on_exit;
  } ctrl_t;

endpackage

// File: rtl/swc_ctrl_reg.sv
module swc_ctrl_reg
  import swc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q.sev_on_pend   <= wdata[BIT_SEV_ON_PEND];
      ctrl_q.deep_sel      <= wdata[BIT_DEEP_SEL];
      ctrl_q.sleep_on_exit <= wdata[BIT_ON_EXIT];
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[BIT_SEV_ON_PEND] = ctrl_q.sev_on_pend;
    rdata[BIT_DEEP_SEL]    = ctrl_q.deep_sel;
    rdata[BIT_ON_EXIT]     = ctrl_q.sleep_on_exit;
  end

  assign ctrl = ctrl_q;

  // Written value of each field is what reads back on the following cycle.
  assert_write_readback_R1: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata[BIT_SEV_ON_PEND] == $past(wdata[BIT_SEV_ON_PEND])) &&
           (rdata[BIT_DEEP_SEL]    == $past(wdata[BIT_DEEP_SEL])) &&
           (rdata[BIT_ON_EXIT]     == $past(wdata[BIT_ON_EXIT])));

  // Without a write, the word keeps its value.
  assert_hold_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    (!we && !$past(rst)) |=> $stable(rdata));

endmodule

// File: rtl/swc_wake_src.sv
module swc_wake_src #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sev_on_pend,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               sev_exec,
  input  logic               ext_event,
  output logic               irq_wake,
  output logic               evt_wake
);

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] rise;
  logic [NUM_IRQ-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= irq_pending;
  end

  assign rise = irq_pending & ~pend_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign hit[i] = rise[i] & (sev_on_pend | irq_enable[i]);
  end

  assign irq_wake = |hit;
  assign evt_wake = irq_wake | sev_exec | ext_event;

  // With send-event-on-pending clear, disabled interrupts can never be a source.
  assert_no_disabled_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (!sev_on_pend && ((irq_pending & irq_enable) == '0) && !sev_exec && !ext_event)
      |-> !evt_wake);

endmodule

// File: rtl/swc_power_fsm.sv
module swc_power_fsm
  import swc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wfe_req,
  input  logic wfi_req,
  input  logic exc_ret_thread,
  input  logic sleep_on_exit,
  input  logic deep_sel,
  input  logic irq_wake,
  input  logic evt_wake,
  output logic sleeping,
  output logic deep_sleep,
  output logic wake_pulse
);

  pwr_state_t state_q, state_n;
  logic ev_q, ev_n;
  logic sleep_q, sleep_n;
  logic deep_q, deep_n;
  logic wake_q, wake_n;
  logic wfi_class;

  assign wfi_class = wfi_req | (exc_ret_thread & sleep_on_exit);

  always_comb begin
    state_n = state_q;
    ev_n    = ev_q;
    sleep_n = sleep_q;
    deep_n  = deep_q;
    wake_n  = 1'b0;
    unique case (state_q)
      PS_AWAKE: begin
        if (wfe_req) begin
          ev_n = 1'b0;
          if (!(ev_q || evt_wake)) begin
            state_n = PS_WFE;
            sleep_n = 1'b1;
            deep_n  = deep_sel;
          end
        end else begin
          if (evt_wake) ev_n = 1'b1;
          if (wfi_class) begin
            if (irq_wake) begin
              ev_n = 1'b0;
            end else begin
              state_n = PS_WFI;
              sleep_n = 1'b1;
              deep_n  = deep_sel;
            end
          end
        end
      end
      PS_WFE: begin
        if (evt_wake) begin
          state_n = PS_WAKING;
          wake_n  = 1'b1;
        end
      end
      PS_WFI: begin
        if (evt_wake) ev_n = 1'b1;
        if (irq_wake) begin
          state_n = PS_WAKING;
          wake_n  = 1'b1;
        end
      end
      PS_WAKING: begin
        if (evt_wake) ev_n = 1'b1;
        state_n = PS_AWAKE;
        sleep_n = 1'b0;
        deep_n  = 1'b0;
      end
      default: state_n = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_AWAKE;
      ev_q    <= 1'b0;
      sleep_q <= 1'b0;
      deep_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ev_q    <= ev_n;
      sleep_q <= sleep_n;
      deep_q  <= deep_n;
      wake_q  <= wake_n;
    end
  end

  assign sleeping   = sleep_q;
  assign deep_sleep = deep_q;
  assign wake_pulse = wake_q;

  assert_deep_needs_sleep_R2: assert property (@(posedge clk) disable iff (rst)
    deep_sleep |-> sleeping);

  assert_wfe_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && wfe_req && !ev_q && !evt_wake) |=> (sleeping && deep_sleep == $past(deep_sel)));

  assert_wake_single_R3: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  assert_wake_clears_R3: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> (!sleeping && !deep_sleep));

  assert_wfe_consumes_R6: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && wfe_req && ev_q) |=> (!sleeping && !ev_q));

  assert_wfi_ignores_evt_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_WFI && !irq_wake) |=> (!wake_pulse && sleeping));

  assert_same_cycle_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (!sleeping && !wfe_req && wfi_req && irq_wake) |=> (!sleeping && !ev_q));

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               wfe_req,
  input  logic               wfi_req,
  input  logic               sev_exec,
  input  logic               ext_event,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               exc_ret_thread,
  output logic               sleeping,
  output logic               deep_sleep,
  output logic               wake_pulse
);

  ctrl_t ctrl;
  logic  irq_wake;
  logic  evt_wake;

  swc_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  swc_wake_src #(.NUM_IRQ(NUM_IRQ)) u_src (
    .clk         (clk),
    .rst         (rst),
    .sev_on_pend (ctrl.sev_on_pend),
    .irq_pending (irq_pending),
    .irq_enable  (irq_enable),
    .sev_exec    (sev_exec),
    .ext_event   (ext_event),
    .irq_wake    (irq_wake),
    .evt_wake    (evt_wake)
  );

  swc_power_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .wfe_req        (wfe_req),
    .wfi_req        (wfi_req),
    .exc_ret_thread (exc_ret_thread),
    .sleep_on_exit  (ctrl.sleep_on_exit),
    .deep_sel       (ctrl.deep_sel),
    .irq_wake       (irq_wake),
    .evt_wake       (evt_wake),
    .sleeping       (sleeping),
    .deep_sleep     (deep_sleep),
    .wake_pulse     (wake_pulse)
  );

endmodule

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;

  localparam int unsigned NUM_IRQ = 8;
  localparam int unsigned DATA_W  = 32;

  logic               clk = 1'b0;
  logic               rst;
  logic               reg_we;
  logic [DATA_W-1:0]  reg_wdata;
  logic [DATA_W-1:0]  reg_rdata;
  logic               wfe_req, wfi_req, sev_exec, ext_event, exc_ret_thread;
  logic [NUM_IRQ-1:0] irq_pending, irq_enable;
  logic               sleeping, deep_sleep, wake_pulse;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wfe_req(wfe_req), .wfi_req(wfi_req), .sev_exec(sev_exec), .ext_event(ext_event),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .exc_ret_thread(exc_ret_thread),
    .sleeping(sleeping), .deep_sleep(deep_sleep), .wake_pulse(wake_pulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outs(string req, logic s, logic d, logic w);
    check(req, {29'd0, s, d, w}, {29'd0, sleeping, deep_sleep, wake_pulse});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    reg_we = 1'b0; reg_wdata = '0;
    wfe_req = 1'b0; wfi_req = 1'b0; sev_exec = 1'b0; ext_event = 1'b0;
    exc_ret_thread = 1'b0; irq_pending = '0; irq_enable = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(logic [31:0] v);
    reg_we = 1'b1; reg_wdata = v;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  // Pulse ext_event for one cycle, sampling after the edge that sees it.
  task automatic pulse_ext();
    ext_event = 1'b1; step(); ext_event = 1'b0;
  endtask

  task automatic pulse_sev();
    sev_exec = 1'b1; step(); sev_exec = 1'b0;
  endtask

  task automatic req_wfe();
    wfe_req = 1'b1; step(); wfe_req = 1'b0;
  endtask

  task automatic req_wfi();
    wfi_req = 1'b1; step(); wfi_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 rdata", reg_rdata, 32'h0);
    outs("R10 outputs", 1'b0, 1'b0, 1'b0);
    req_wfe();
    outs("R10 event reg clear so WFE sleeps", 1'b1, 1'b0, 1'b0);
    pulse_ext(); step();
  endtask

  task automatic t_reg();
    do_reset();
    wr(32'hFFFF_FFFF);
    check("R1 all ones", reg_rdata, 32'h0000_0016);
    wr(32'h0000_0010);
    check("R1 sev-on-pend only", reg_rdata, 32'h0000_0010);
    wr(32'hFFFF_FFE9);
    check("R1 reserved ignored", reg_rdata, 32'h0000_0000);
  endtask

  task automatic t_wfe_ext();
    do_reset();
    req_wfe();
    outs("R2 sleep after WFE", 1'b1, 1'b0, 1'b0);
    step(); step(); step();
    outs("R2 stays asleep", 1'b1, 1'b0, 1'b0);
    pulse_ext();
    outs("R3 wake pulse", 1'b1, 1'b0, 1'b1);
    step();
    outs("R3 flags clear after pulse", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_deep();
    do_reset();
    wr(32'h0000_0004);
    req_wfe();
    outs("R2 deep sleep entry", 1'b1, 1'b1, 1'b0);
    pulse_sev();
    outs("R3 send-event wakes", 1'b1, 1'b1, 1'b1);
    step();
    outs("R3 deep clears", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_irq();
    do_reset();
    irq_enable = 8'h02;
    req_wfi();
    outs("R4 WFI sleeps", 1'b1, 1'b0, 0);
    irq_pending = 8'h02; step();
    outs("R4 enabled rise wakes", 1'b1, 1'b0, 1'b1);
    step();
    outs("R4 awake", 1'b0, 1'b0, 1'b0);
    req_wfi();
    step(); step(); step();
    outs("R4 held pending gives no wake", 1'b1, 1'b0, 1'b0);
    irq_pending = 8'h00; step();
    irq_pending = 8'h02; step();
    outs("R4 new rise wakes", 1'b1, 1'b0, 1'b1);
    step();
  endtask

  task automatic t_disabled();
    do_reset();
    irq_enable = 8'h01;
    req_wfi();
    irq_pending = 8'h08; step(); step(); step(); step();
    outs("R5 disabled rise ignored in WFI", 1'b1, 1'b0, 1'b0);
    irq_pending = 8'h09; step();
    outs("R5 enabled rise wakes", 1'b1, 1'b0, 1'b1);
    do_reset();
    irq_pending = 8'h04; step(); irq_pending = 8'h00; step();
    req_wfe();
    outs("R5 disabled rise not latched", 1'b1, 1'b0, 1'b0);
    pulse_ext(); step();
    wr(32'h0000_0010);
    req_wfe();
    outs("R5 WFE sleep with sev-on-pend", 1'b1, 1'b0, 1'b0);
    irq_pending = 8'h20; step();
    outs("R5 disabled rise wakes when bit set", 1'b1, 1'b0, 1'b1);
    step();
    irq_pending = 8'h00;
  endtask

  task automatic t_latch();
    do_reset();
    pulse_ext(); step();
    req_wfe();
    outs("R6 stored event blocks sleep", 1'b0, 1'b0, 1'b0);
    step();
    req_wfe();
    outs("R6 next WFE sleeps", 1'b1, 1'b0, 1'b0);
    pulse_ext(); step();
  endtask

  task automatic t_wfi_evt();
    do_reset();
    irq_enable = 8'h01;
    req_wfi();
    pulse_sev(); step(); pulse_ext(); step();
    outs("R7 events do not wake WFI", 1'b1, 1'b0, 1'b0);
    irq_pending = 8'h01; step();
    outs("R7 interrupt wakes WFI", 1'b1, 1'b0, 1'b1);
    step(); irq_pending = 8'h00; step();
    req_wfe();
    outs("R7 event recorded during WFI", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_onexit();
    do_reset();
    irq_enable = 8'h01;
    exc_ret_thread = 1'b1; step(); exc_ret_thread = 1'b0;
    outs("R8 no sleep when bit clear", 1'b0, 1'b0, 1'b0);
    wr(32'h0000_0006);
    exc_ret_thread = 1'b1; step(); exc_ret_thread = 1'b0;
    outs("R8 sleep-on-exit deep", 1'b1, 1'b1, 1'b0);
    pulse_ext();
    outs("R8 event does not wake exit sleep", 1'b1, 1'b1, 1'b0);
    irq_pending = 8'h01; step();
    outs("R8 interrupt wakes", 1'b1, 1'b1, 1'b1);
    step();
    outs("R8 awake again", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_same();
    do_reset();
    wfe_req = 1'b1; ext_event = 1'b1; step(); wfe_req = 1'b0; ext_event = 1'b0;
    outs("R9 WFE with same-cycle event", 1'b0, 1'b0, 1'b0);
    req_wfe();
    outs("R9 event consumed so WFE sleeps", 1'b1, 1'b0, 1'b0);
    pulse_ext(); step();
    irq_enable = 8'h01;
    wfi_req = 1'b1; irq_pending = 8'h01; step(); wfi_req = 1'b0;
    outs("R9 WFI with same-cycle interrupt", 1'b0, 1'b0, 1'b0);
    req_wfe();
    outs("R9 register clear after same-cycle WFI", 1'b1, 1'b0, 1'b0);
    pulse_ext(); step();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_reg();
    t_wfe_ext();
    t_deep();
    t_irq();
    t_disabled();
    t_latch();
    t_wfi_evt();
    t_onexit();
    t_same();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule